// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a parameterised storage and shift register, eight bits wide by default, whose parallel data path is shared with its outputs. A two-bit select picks one of four actions on each rising clock edge: keep the contents, shift toward the high end, shift toward the low end, or capture a parallel word. The parallel word arrives on the same port lanes that carry the register contents out. Each lane is modelled as three signals: a driven value, an enable for that value, and a received value. A top-level pad wrapper can join them into a true bidirectional pin.

Two serial end outputs always drive the lowest and highest stored bits. They are never switched off, so several instances can be chained into a longer word by feeding the high-end output into the next instance's low-side serial input. An active-low clear acts at once, without the clock. Two active-high disable inputs release the port lanes but leave the stored data untouched.

Top module: `usr_shift_reg`

## Requirements
- R1: While `clr_n` is low, all stored bits, `pin_out`, `end_lo` and `end_hi` read 0 at once, without a clock edge and whatever `sel` is.
- R2: With `sel` = 2'b00, a clock edge leaves the stored word unchanged.
- R3: With `sel` = 2'b01, a clock edge loads `ser_r_in` into bit 0, and each bit i > 0 takes the old value of bit i-1.
- R4: With `sel` = 2'b10, a clock edge loads `ser_l_in` into bit WIDTH-1, and each bit i < WIDTH-1 takes the old value of bit i+1.
- R5: With `sel` = 2'b11, a clock edge captures `pin_in` into the register, bit for bit.
- R6: While `sel` = 2'b11, every bit of `pin_oe` is 0, whatever the disable inputs are.
- R7: While `dis_a` or `dis_b` is 1, every bit of `pin_oe` is 0, and the hold, shift, load and clear actions behave exactly as they do with both disables low.
- R8: When both disables are 0 and `sel` is not 2'b11, every bit of `pin_oe` is 1; `pin_out` equals the stored word in every mode.
- R9: `end_lo` equals stored bit 0 and `end_hi` equals stored bit WIDTH-1 at all times, independent of the disables and of `sel`, so that two instances joined through `end_hi` to `ser_r_in` shift as one register of twice the width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel | input | 2 | Action select: 00 keep, 01 shift up, 10 shift down, 11 parallel capture |
| dis_a | input | 1 | Port disable, active high |
| dis_b | input | 1 | Port disable, active high |
| ser_r_in | input | 1 | Serial bit entering bit 0 on an upward shift |
| ser_l_in | input | 1 | Serial bit entering bit WIDTH-1 on a downward shift |
| pin_in | input | WIDTH | Value received on the port lanes |
| pin_out | output | WIDTH | Value driven on the port lanes (the stored word) |
| pin_oe | output | WIDTH | Per-lane drive enable |
| end_lo | output | 1 | Stored bit 0, always driven |
| end_hi | output | 1 | Stored bit WIDTH-1, always driven |

## Verification
On every cycle the assertions check the next-state relation of each action against the port values one edge earlier, the lane enables against the select and disable inputs, and that the end outputs track the extreme bits. What only the bench scenarios show is the clear taking effect in the middle of a clock period, that shifting and capture under a raised disable match an independent model, the full sweep of every parallel word through capture, and a sixteen-step run across a two-instance chain with the disables held high.

// File: rtl/usr_pkg.sv
// Shared types for the universal shift register.
// Assumes the select encoding below is fixed, since the bench and the
// decode logic both rely on it.
package usr_pkg;
    typedef enum logic [1:0] {
        ACT_KEEP  = 2'b00,
        ACT_UP    = 2'b01,
        ACT_DOWN  = 2'b10,
        ACT_LOAD  = 2'b11
    } usr_act_e;
endpackage

// File: rtl/usr_ctrl_decode.sv
// Turns the raw select and disable inputs into an action code and a
// lane-drive enable. Purely combinational; assumes inputs are settled
// before the clock edge.
module usr_ctrl_decode
    import usr_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       dis_a,
    input  logic       dis_b,
    output usr_act_e   act,
    output logic       drive_en
);
    // Decode action and lane enable.
    always_comb begin
        act      = usr_act_e'(sel);
        drive_en = !(dis_a || dis_b) && (act != ACT_LOAD);
    end
endmodule

// File: rtl/usr_stage.sv
// Next-state selector for one register bit. Takes its own value, its
// lower and upper neighbours and the parallel lane value; picks one
// according to the action. Assumes neighbours at the ends are the
// serial inputs.
module usr_stage
    import usr_pkg::*;
(
    input  usr_act_e act,
    input  logic     cur,
    input  logic     lower,
    input  logic     upper,
    input  logic     par,
    output logic     nxt
);
    // Pick the source for this bit.
    always_comb begin
        unique case (act)
            ACT_KEEP: nxt = cur;
            ACT_UP:   nxt = lower;
            ACT_DOWN: nxt = upper;
            ACT_LOAD: nxt = par;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/usr_shift_reg.sv
// Universal shift register with shared parallel lanes and two always-on
// serial end outputs. Storage clears asynchronously on clr_n low; all
// other actions happen on the rising clock edge. Assumes WIDTH >= 2.
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       sel,
    input  logic             dis_a,
    input  logic             dis_b,
    input  logic             ser_r_in,
    input  logic             ser_l_in,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic             end_lo,
    output logic             end_hi
);
    localparam int TOP = WIDTH - 1;

    usr_act_e         act;
    logic             drive_en;
    logic [WIDTH-1:0] store_q;
    logic [WIDTH-1:0] store_d;

    usr_ctrl_decode u_dec (
        .sel      (sel),
        .dis_a    (dis_a),
        .dis_b    (dis_b),
        .act      (act),
        .drive_en (drive_en)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic lo_src;
        logic hi_src;
        if (i == 0) begin : g_first
            assign lo_src = ser_r_in;
        end else begin : g_lo
            assign lo_src = store_q[i-1];
        end
        if (i == TOP) begin : g_last
            assign hi_src = ser_l_in;
        end else begin : g_hi
            assign hi_src = store_q[i+1];
        end
        usr_stage u_stage (
            .act   (act),
            .cur   (store_q[i]),
            .lower (lo_src),
            .upper (hi_src),
            .par   (pin_in[i]),
            .nxt   (store_d[i])
        );
    end

    // Storage with asynchronous active-low clear.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) store_q <= '0;
        else        store_q <= store_d;
    end

    // Drive the lanes and the end outputs.
    always_comb begin
        pin_out = store_q;
        pin_oe  = {WIDTH{drive_en}};
        end_lo  = store_q[0];
        end_hi  = store_q[TOP];
    end
endmodule

// File: rtl/usr_shift_reg_chk.sv
// Cycle-level checker for usr_shift_reg, bound to every instance.
// Observes ports only.
module usr_shift_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic [1:0]       sel,
    input logic             dis_a,
    input logic             dis_b,
    input logic             ser_r_in,
    input logic             ser_l_in,
    input logic [WIDTH-1:0] pin_in,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] pin_oe,
    input logic             end_lo,
    input logic             end_hi
);
    a_r1_clear: assert property (@(posedge clk)
        !clr_n |-> (pin_out == '0 && !end_lo && !end_hi));

    a_r2_keep: assert property (@(posedge clk) disable iff (!clr_n)
        sel == 2'b00 |=> $stable(pin_out));

    a_r3_up: assert property (@(posedge clk) disable iff (!clr_n)
        sel == 2'b01 |=> (pin_out[0] == $past(ser_r_in) &&
                          pin_out[WIDTH-1:1] == $past(pin_out[WIDTH-2:0])));

    a_r4_down: assert property (@(posedge clk) disable iff (!clr_n)
        sel == 2'b10 |=> (pin_out[WIDTH-1] == $past(ser_l_in) &&
                          pin_out[WIDTH-2:0] == $past(pin_out[WIDTH-1:1])));

    a_r5_load: assert property (@(posedge clk) disable iff (!clr_n)
        sel == 2'b11 |=> pin_out == $past(pin_in));

    a_r6_load_float: assert property (@(posedge clk)
        sel == 2'b11 |-> pin_oe == '0);

    a_r7_disable: assert property (@(posedge clk)
        (dis_a || dis_b) |-> pin_oe == '0);

    a_r8_enable: assert property (@(posedge clk)
        (!dis_a && !dis_b && sel != 2'b11) |-> pin_oe == '1);

    a_r9_ends: assert property (@(posedge clk)
        (end_lo == pin_out[0] && end_hi == pin_out[WIDTH-1]));
endmodule

bind usr_shift_reg usr_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_usr_shift_reg.sv
`timescale 1ns/1ps
module sim_usr_shift_reg;
    localparam int W = 8;

    logic         clk = 0;
    logic         clr_n = 0;
    logic [1:0]   sel = 0;
    logic         dis_a = 0, dis_b = 0, ser_r_in = 0, ser_l_in = 0;
    logic [W-1:0] pin_in = 0;
    logic [W-1:0] pin_out, pin_oe;
    logic         end_lo, end_hi;

    logic [1:0]   c_sel = 0;
    logic         c_ser = 0;
    logic [W-1:0] c1_out, c1_oe, c2_out, c2_oe;
    logic         c1_lo, c1_hi, c2_lo, c2_hi;

    int checks = 0;
    int errors = 0;
    logic [W-1:0]  model = 0;
    logic [15:0]   model16 = 0;
    bit done = 0;

    always #5 clk = ~clk;

    usr_shift_reg #(.WIDTH(W)) u0 (
        .clk(clk), .clr_n(clr_n), .sel(sel), .dis_a(dis_a), .dis_b(dis_b),
        .ser_r_in(ser_r_in), .ser_l_in(ser_l_in), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .end_lo(end_lo), .end_hi(end_hi));

    // Two-instance chain, ports disabled, low half feeds the high half.
    usr_shift_reg #(.WIDTH(W)) u1 (
        .clk(clk), .clr_n(clr_n), .sel(c_sel), .dis_a(1'b1), .dis_b(1'b0),
        .ser_r_in(c_ser), .ser_l_in(c2_lo), .pin_in('0),
        .pin_out(c1_out), .pin_oe(c1_oe), .end_lo(c1_lo), .end_hi(c1_hi));
    usr_shift_reg #(.WIDTH(W)) u2 (
        .clk(clk), .clr_n(clr_n), .sel(c_sel), .dis_a(1'b0), .dis_b(1'b1),
        .ser_r_in(c1_hi), .ser_l_in(1'b0), .pin_in('0),
        .pin_out(c2_out), .pin_oe(c2_oe), .end_lo(c2_lo), .end_hi(c2_hi));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clocked action on u0; model updated from the requirements.
    task automatic step(logic [1:0] s, logic sr, logic sl, logic [W-1:0] par,
                        logic da, logic db, string req);
        @(negedge clk);
        sel = s; ser_r_in = sr; ser_l_in = sl; pin_in = par;
        dis_a = da; dis_b = db;
        #1;
        check({req, " lane enable"}, {24'd0, pin_oe},
              (s == 2'b11 || da || db) ? 32'd0 : {24'd0, {W{1'b1}}});
        case (s)
            2'b00: model = model;
            2'b01: model = {model[W-2:0], sr};
            2'b10: model = {sl, model[W-1:1]};
            default: model = par;
        endcase
        @(posedge clk); #1;
        check(req, {24'd0, pin_out}, {24'd0, model});
        check({req, " R9 ends"}, {30'd0, end_hi, end_lo},
              {30'd0, model[W-1], model[0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1;
        check("R1 reset word", {24'd0, pin_out}, 32'd0);
        check("R1 reset ends", {30'd0, end_hi, end_lo}, 32'd0);
        @(negedge clk); clr_n = 1;

        // R5: every parallel word, alternately with disables raised (R7).
        for (int v = 0; v < 256; v++)
            step(2'b11, 1'b0, 1'b0, W'(v), v[0], v[1], "R5 R6 load");

        // R2: keep, with random lane noise that must be ignored.
        for (int k = 0; k < 8; k++)
            step(2'b00, 1'($urandom), 1'($urandom), W'($urandom), 1'(k), 1'b0, "R2 keep");

        // R3 and R4: random serial data, some with disables raised (R7).
        for (int k = 0; k < 40; k++)
            step(2'b01, 1'($urandom), 1'($urandom), W'($urandom), k[2], k[3], "R3 up");
        for (int k = 0; k < 40; k++)
            step(2'b10, 1'($urandom), 1'($urandom), W'($urandom), k[3], k[2], "R4 down");
        for (int k = 0; k < 60; k++)
            step(2'($urandom), 1'($urandom), 1'($urandom), W'($urandom),
                 1'($urandom), 1'($urandom), "R8 mixed");

        // R1: clear in the middle of a period, with load selected.
        step(2'b11, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, "R5 preload");
        @(posedge clk); #3;
        clr_n = 0; #1;
        check("R1 mid-cycle clear word", {24'd0, pin_out}, 32'd0);
        check("R1 mid-cycle clear ends", {30'd0, end_hi, end_lo}, 32'd0);
        @(posedge clk); #1;
        check("R1 clear held over edge", {24'd0, pin_out}, 32'd0);
        model = 0; model16 = 0;
        @(negedge clk); clr_n = 1;

        // R9: sixteen-step upward shift across the chain, lanes disabled.
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            c_sel = 2'b01; c_ser = 1'($urandom);
            model16 = {model16[14:0], c_ser};
            @(posedge clk); #1;
            check("R9 chain word", {16'd0, c2_out, c1_out}, {16'd0, model16});
        end
        check("R7 chain lanes off", {16'd0, c2_oe, c1_oe}, 32'd0);
        check("R9 chain top end", {31'd0, c2_hi}, {31'd0, model16[15]});

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule